// File: doc/BRIEF.md
# DRAM Bank Open-Row State Tracker

The tracker follows the row state of every bank behind a memory controller. Each bank is idle, active with one open row, or closing (precharging). The controller presents one decoded command per cycle with a bank number and the row-close flag. The flag is address bit 10 on a column command and the all-banks selector on a close command. The tracker accepts the command or rejects it. Its outputs show, per bank, whether a column access may be issued, whether an ACTIVATE may be issued, and when an automatic row close begins.

Three timing limits are enforced, each set by a parameter in clock cycles: the minimum open-row time before a close (`T_RAS`), the close recovery time before the next ACTIVATE (`T_RP`), and the data burst length (`BURST_LEN`). A column command with the flag set closes its own row on its own. The close starts at the first cycle in which a manual close would be legal, which means that the burst has finished and the minimum open-row time has passed. A rejected command changes no state. It produces an error pulse in the following cycle.

Top module: `bank_prech_tracker`

## Requirements
- R1: A close command (`cmd_i`=4) with `a10_i`=1 targets every bank and ignores `ba_i`. It is accepted only if every active bank has met `T_RAS` and has no pending automatic close, and then all active banks start closing. With `a10_i`=0 it targets only bank `ba_i`.
- R2: Command codes on `cmd_i`: 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE, 4 close, 5 burst stop. A READ or WRITE is legal only where `rw_ok_o[ba_i]` is 1, and an ACTIVATE only where `idle_o[ba_i]` is 1. An illegal command sets `err_o` to 1 for exactly the one cycle after the edge that captured it, and it leaves all bank state unchanged.
- R3: A close addressed to a bank that is idle or already closing is dropped with no error, and it does not restart that bank's recovery time.
- R4: `a10_i`=1 on a READ or WRITE requests an automatic close for that command only. A later READ or WRITE with `a10_i`=0 leaves the row open indefinitely.
- R5: A READ or WRITE with `a10_i`=1 captured at edge r, to a bank activated at edge a, begins the close at edge max(r+`BURST_LEN`, a+`T_RAS`). `ap_start_o` for that bank is 1 during the cycle that ends at that edge, and after that edge `rw_ok_o` for the bank is 0.
- R6: Once a close starts at edge p, every command to that bank except a close (which is dropped) is rejected until edge p+`T_RP`. An ACTIVATE is legal from edge p+`T_RP` on, and `idle_o` rises after edge p+`T_RP`-1.
- R7: A burst stop cuts short a READ burst in progress that has no automatic close. `burst_busy_o` drops after the edge that captures it, and the row stays open. If the READ in progress has an automatic close, the burst stop is rejected and the burst continues.
- R8: While a burst with an automatic close still has more than its last beat to transfer, a READ or WRITE to any bank is rejected. A READ or WRITE in its last beat cycle is accepted.
- R9: A manual close to an active bank before edge a+`T_RAS` (ACTIVATE at edge a) is rejected, and the row stays open.
- R10: After reset, every bank is idle: `idle_o` is all ones, and `rw_ok_o`, `ap_start_o`, `burst_busy_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 3 | Command code (see R2) |
| ba_i | input | $clog2(NUM_BANKS) | Bank number |
| a10_i | input | 1 | Automatic-close / all-banks flag |
| rw_ok_o | output | NUM_BANKS | READ/WRITE legal per bank |
| idle_o | output | NUM_BANKS | ACTIVATE legal per bank |
| ap_start_o | output | NUM_BANKS | Automatic close starts at next edge |
| burst_busy_o | output | 1 | Data burst in progress |
| err_o | output | 1 | Previous command was rejected |

## Verification
The hardest case to reach is the boundary between the two automatic-close triggers. The close must wait for whichever comes later, the end of the burst or the minimum open-row time, and the two can be a single cycle apart. The stimulus places the column command once right after ACTIVATE, so that the open-row time decides, and once late, so that the burst end decides. It then samples `ap_start_o` in the cycles on both sides of the expected edge. A second test issues a command to another bank exactly on the last beat of a burst with an automatic close, and one beat earlier, to probe the concurrency boundary.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECH  = 2'd2
  } bank_st_e;
endpackage

// File: rtl/bpt_bank.sv
module bpt_bank
  import bpt_pkg::*;
#(
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  localparam int RAS_W = $clog2(T_RAS + 1),
  localparam int RP_W  = $clog2(T_RP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rw_i,
  input  logic rw_ap_i,
  input  logic pre_i,
  input  logic burst_hold_i,
  output logic act_ok_o,
  output logic rw_free_o,
  output logic pre_ok_o,
  output logic open_o,
  output logic ap_start_o
);
  bank_st_e          state_q;
  logic [RAS_W-1:0]  ras_q;
  logic [RP_W-1:0]   rp_q;
  logic              ap_pend_q;
  logic              ras_met, rp_done, ap_go;

  assign ras_met    = (ras_q == '0);
  assign rp_done    = (rp_q == '0);
  assign open_o     = (state_q == BK_ACTIVE);
  assign act_ok_o   = (state_q == BK_IDLE) || ((state_q == BK_PRECH) && rp_done);
  assign rw_free_o  = open_o && !ap_pend_q;
  assign pre_ok_o   = rw_free_o && ras_met;
  // earliest legal close: row time met and own burst at last beat
  assign ap_go      = open_o && ap_pend_q && ras_met && !burst_hold_i;
  assign ap_start_o = ap_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= BK_IDLE;
      ras_q     <= '0;
      rp_q      <= '0;
      ap_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        BK_IDLE: begin
          if (act_i) begin
            state_q   <= BK_ACTIVE;
            ras_q     <= RAS_W'(T_RAS - 1);
            ap_pend_q <= 1'b0;
          end
        end
        BK_PRECH: begin
          if (!rp_done) rp_q <= rp_q - RP_W'(1);
          if (act_i) begin
            state_q   <= BK_ACTIVE;
            ras_q     <= RAS_W'(T_RAS - 1);
            ap_pend_q <= 1'b0;
          end else if (rp_done) begin
            state_q <= BK_IDLE;
          end
        end
        BK_ACTIVE: begin
          if (!ras_met) ras_q <= ras_q - RAS_W'(1);
          if (ap_go || pre_i) begin
            state_q   <= BK_PRECH;
            rp_q      <= RP_W'(T_RP - 1);
            ap_pend_q <= 1'b0;
          end else if (rw_i) begin
            ap_pend_q <= rw_ap_i;
          end
        end
        default: state_q <= BK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bpt_bus.sv
module bpt_bus #(
  parameter int BURST_LEN = 4,
  parameter int BA_W      = 2,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [BA_W-1:0] start_bank_i,
  input  logic            start_ap_i,
  input  logic            start_rd_i,
  input  logic            cut_i,
  output logic            busy_o,
  output logic            tail_o,
  output logic [BA_W-1:0] owner_o,
  output logic            ap_lock_o,
  output logic            rd_plain_o,
  output logic            rd_ap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [BA_W-1:0]  owner_q;
  logic             ap_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      owner_q <= '0;
      ap_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CNT_W'(BURST_LEN);
      owner_q <= start_bank_i;
      ap_q    <= start_ap_i;
      rd_q    <= start_rd_i;
    end else if (cut_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o     = (cnt_q != '0);
  // more than the last beat still to go
  assign tail_o     = (cnt_q > CNT_W'(1));
  assign owner_o    = owner_q;
  assign ap_lock_o  = ap_q && tail_o;
  assign rd_plain_o = busy_o && rd_q && !ap_q;
  assign rd_ap_o    = busy_o && rd_q && ap_q;
endmodule

// File: rtl/bpt_decode.sv
module bpt_decode
  import bpt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 cmd_valid_i,
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  input  logic [NUM_BANKS-1:0] act_ok_i,
  input  logic [NUM_BANKS-1:0] rw_free_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic                 ap_lock_i,
  input  logic                 rd_plain_i,
  input  logic                 rd_ap_i,
  output logic [NUM_BANKS-1:0] act_o,
  output logic [NUM_BANKS-1:0] rw_o,
  output logic [NUM_BANKS-1:0] pre_o,
  output logic                 bus_start_o,
  output logic                 bus_rd_o,
  output logic                 cut_o,
  output logic                 err_o
);
  logic all_ok;
  assign all_ok = &(~open_i | pre_ok_i);

  always_comb begin
    act_o       = '0;
    rw_o        = '0;
    pre_o       = '0;
    bus_start_o = 1'b0;
    bus_rd_o    = 1'b0;
    cut_o       = 1'b0;
    err_o       = 1'b0;
    if (cmd_valid_i) begin
      unique case (cmd_i)
        CMD_ACT: begin
          if (act_ok_i[ba_i]) act_o[ba_i] = 1'b1;
          else                err_o       = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (rw_free_i[ba_i] && !ap_lock_i) begin
            rw_o[ba_i]  = 1'b1;
            bus_start_o = 1'b1;
            bus_rd_o    = (cmd_i == CMD_RD);
          end else begin
            err_o = 1'b1;
          end
        end
        CMD_PRE: begin
          if (a10_i) begin
            if (all_ok) pre_o = open_i;
            else        err_o = 1'b1;
          end else if (open_i[ba_i]) begin
            if (pre_ok_i[ba_i]) pre_o[ba_i] = 1'b1;
            else                err_o       = 1'b1;
          end
        end
        CMD_BST: begin
          if (rd_ap_i)         err_o = 1'b1;
          else if (rd_plain_i) cut_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_prech_tracker.sv
module bank_prech_tracker
  import bpt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  output logic [NUM_BANKS-1:0] rw_ok_o,
  output logic [NUM_BANKS-1:0] idle_o,
  output logic [NUM_BANKS-1:0] ap_start_o,
  output logic                 burst_busy_o,
  output logic                 err_o
);
  logic [NUM_BANKS-1:0] act_ok, rw_free, pre_ok, open_b, hold;
  logic [NUM_BANKS-1:0] do_act, do_rw, do_pre;
  logic                 bus_start, bus_rd, cut, err_d, err_q;
  logic                 bus_tail, ap_lock, rd_plain, rd_ap;
  logic [BA_W-1:0]      owner;

  bpt_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_e'(cmd_i)),
    .ba_i        (ba_i),
    .a10_i       (a10_i),
    .act_ok_i    (act_ok),
    .rw_free_i   (rw_free),
    .pre_ok_i    (pre_ok),
    .open_i      (open_b),
    .ap_lock_i   (ap_lock),
    .rd_plain_i  (rd_plain),
    .rd_ap_i     (rd_ap),
    .act_o       (do_act),
    .rw_o        (do_rw),
    .pre_o       (do_pre),
    .bus_start_o (bus_start),
    .bus_rd_o    (bus_rd),
    .cut_o       (cut),
    .err_o       (err_d)
  );

  bpt_bus #(.BURST_LEN(BURST_LEN), .BA_W(BA_W)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (bus_start),
    .start_bank_i (ba_i),
    .start_ap_i   (a10_i),
    .start_rd_i   (bus_rd),
    .cut_i        (cut),
    .busy_o       (burst_busy_o),
    .tail_o       (bus_tail),
    .owner_o      (owner),
    .ap_lock_o    (ap_lock),
    .rd_plain_o   (rd_plain),
    .rd_ap_o      (rd_ap)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hold[b] = bus_tail && (owner == BA_W'(b));

    bpt_bank #(.T_RAS(T_RAS), .T_RP(T_RP)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .act_i        (do_act[b]),
      .rw_i         (do_rw[b]),
      .rw_ap_i      (a10_i),
      .pre_i        (do_pre[b]),
      .burst_hold_i (hold[b]),
      .act_ok_o     (act_ok[b]),
      .rw_free_o    (rw_free[b]),
      .pre_ok_o     (pre_ok[b]),
      .open_o       (open_b[b]),
      .ap_start_o   (ap_start_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o   = err_q;
  assign idle_o  = act_ok;
  assign rw_ok_o = rw_free & ~{NUM_BANKS{ap_lock}};
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [2:0]           cmd_i,
  input logic [BA_W-1:0]      ba_i,
  input logic                 a10_i,
  input logic [NUM_BANKS-1:0] rw_ok_o,
  input logic [NUM_BANKS-1:0] idle_o,
  input logic [NUM_BANKS-1:0] ap_start_o,
  input logic                 burst_busy_o,
  input logic                 err_o
);
  AST_ERR_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i)); // R2

  AST_COL_ILLEGAL_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_i == 3'd2 || cmd_i == 3'd3) && !rw_ok_o[ba_i]) |=> err_o); // R2

  AST_COL_LEGAL_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_i == 3'd2 || cmd_i == 3'd3) && rw_ok_o[ba_i]) |=> (burst_busy_o && !err_o)); // R8

  AST_CLOSE_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd4 && !a10_i && idle_o[ba_i]) |=> !err_o); // R3

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_AP_CLOSES_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ap_start_o[b] |=> !rw_ok_o[b]); // R5

    AST_OPEN_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rw_ok_o[b] |-> !idle_o[b]); // R2
  end
endmodule

bind bank_prech_tracker bpt_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .ba_i         (ba_i),
  .a10_i        (a10_i),
  .rw_ok_o      (rw_ok_o),
  .idle_o       (idle_o),
  .ap_start_o   (ap_start_o),
  .burst_busy_o (burst_busy_o),
  .err_o        (err_o)
);

// File: tb/sim_bank_prech_tracker.sv
`timescale 1ns/1ps
module sim_bank_prech_tracker;
  localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] ba_i = 2'd0;
  logic       a10_i = 1'b0;
  logic [3:0] rw_ok_o, idle_o, ap_start_o;
  logic       burst_busy_o, err_o;
  int total = 0;
  int bad = 0;

  always #2ns clk_i = ~clk_i;

  bank_prech_tracker #(.NUM_BANKS(4), .T_RAS(6), .T_RP(3), .BURST_LEN(4)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .ba_i(ba_i), .a10_i(a10_i), .rw_ok_o(rw_ok_o), .idle_o(idle_o),
    .ap_start_o(ap_start_o), .burst_busy_o(burst_busy_o), .err_o(err_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drive at a falling edge; returns at the falling edge after capture
  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic a);
    cmd_valid_i = 1'b1; cmd_i = c; ba_i = b; a10_i = a;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_i = 3'd0; ba_i = 2'd0; a10_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 idle", idle_o, 4'hF);
    chk("R10 rw_ok", rw_ok_o, 4'h0);
    chk("R10 ap", ap_start_o, 4'h0);
    chk("R10 busy", burst_busy_o, 1'b0);
    chk("R10 err", err_o, 1'b0);
  endtask

  task automatic t_illegal();
    do_reset();
    issue(RD, 2'd0, 1'b0);
    chk("R2 read idle err", err_o, 1'b1);
    chk("R2 read idle state", rw_ok_o, 4'h0);
    step(1);
    chk("R2 err one cycle", err_o, 1'b0);
    issue(ACT, 2'd1, 1'b0);
    chk("R2 act ok", err_o, 1'b0);
    chk("R2 act rw_ok", rw_ok_o, 4'b0010);
    chk("R2 act idle", idle_o, 4'b1101);
    issue(ACT, 2'd1, 1'b0);
    chk("R2 act twice err", err_o, 1'b1);
    chk("R2 act twice state", rw_ok_o, 4'b0010);
    issue(WR, 2'd1, 1'b0);
    chk("R2 write ok", err_o, 1'b0);
    chk("R2 write burst", burst_busy_o, 1'b1);
  endtask

  task automatic t_timing();
    do_reset();
    issue(ACT, 2'd1, 1'b0);            // edge a
    issue(PRE, 2'd1, 1'b0);            // a+1
    chk("R9 early close err", err_o, 1'b1);
    chk("R9 row open", rw_ok_o[1], 1'b1);
    step(4);
    issue(PRE, 2'd1, 1'b0);            // a+6 = p
    chk("R9 close at tRAS ok", err_o, 1'b0);
    chk("R9 closing", {rw_ok_o[1], idle_o[1]}, 2'b00);
    issue(PRE, 2'd1, 1'b0);            // p+1, dropped
    chk("R3 close closing no err", err_o, 1'b0);
    chk("R6 not idle yet", idle_o[1], 1'b0);
    step(1);                           // after p+2
    chk("R3 no restart / R6 idle", idle_o[1], 1'b1);
    issue(ACT, 2'd1, 1'b0);            // q = p+3
    chk("R6 act after tRP", err_o, 1'b0);
    step(5);
    issue(PRE, 2'd1, 1'b0);            // q+6
    chk("R6 close2 ok", err_o, 1'b0);
    issue(ACT, 2'd1, 1'b0);            // q+7
    chk("R6 act in tRP err", err_o, 1'b1);
    issue(ACT, 2'd1, 1'b0);            // q+8
    chk("R6 act in tRP err2", err_o, 1'b1);
    issue(ACT, 2'd1, 1'b0);            // q+9
    chk("R6 act at tRP ok", err_o, 1'b0);
    chk("R6 reopened", rw_ok_o[1], 1'b1);
    issue(PRE, 2'd2, 1'b0);
    chk("R3 close idle no err", err_o, 1'b0);
    chk("R3 close idle state", idle_o, 4'b1101);
  endtask

  task automatic t_allbank();
    do_reset();
    issue(ACT, 2'd0, 1'b0);            // a
    issue(ACT, 2'd3, 1'b0);            // a+1
    issue(PRE, 2'd2, 1'b1);            // a+2
    chk("R1 all early err", err_o, 1'b1);
    chk("R1 all early state", rw_ok_o, 4'b1001);
    step(4);
    issue(PRE, 2'd2, 1'b1);            // a+7
    chk("R1 all ok", err_o, 1'b0);
    chk("R1 all closed", rw_ok_o, 4'b0000);
    chk("R1 all closing", idle_o, 4'b0110);
    step(2);
    chk("R1 all idle", idle_o, 4'hF);
    issue(ACT, 2'd0, 1'b0);
    issue(ACT, 2'd3, 1'b0);
    step(5);
    issue(PRE, 2'd3, 1'b0);
    chk("R1 single err", err_o, 1'b0);
    chk("R1 single bank only", rw_ok_o, 4'b0001);
  endtask

  task automatic t_auto();
    do_reset();
    issue(ACT, 2'd0, 1'b0);            // a
    issue(RD, 2'd0, 1'b1);             // a+1
    chk("R5 pending blocks", rw_ok_o[0], 1'b0);
    issue(RD, 2'd0, 1'b0);             // a+2
    chk("R5 same bank err", err_o, 1'b1);
    step(2);                           // after a+4
    chk("R5 not yet", ap_start_o, 4'h0);
    step(1);                           // after a+5
    chk("R5 start tRAS-bound", ap_start_o, 4'b0001);
    step(1);                           // after a+6
    chk("R5 start pulse ends", ap_start_o, 4'h0);
    chk("R5 closed", {rw_ok_o[0], idle_o[0]}, 2'b00);
    step(2);
    chk("R6 idle after ap", idle_o[0], 1'b1);
    issue(ACT, 2'd0, 1'b0);
    issue(RD, 2'd0, 1'b0);
    step(12);
    chk("R4 no persist open", rw_ok_o[0], 1'b1);
    chk("R4 no persist ap", ap_start_o, 4'h0);
    issue(ACT, 2'd1, 1'b0);            // b
    step(3);
    issue(WR, 2'd1, 1'b1);             // b+4, burst ends b+8
    step(2);                           // after b+6
    chk("R5 burst-bound wait", ap_start_o, 4'h0);
    step(1);                           // after b+7
    chk("R5 start burst-bound", ap_start_o, 4'b0010);
    step(1);
    chk("R5 burst-bound closed", rw_ok_o[1], 1'b0);
  endtask

  task automatic t_bst();
    do_reset();
    issue(ACT, 2'd2, 1'b0);            // a
    issue(RD, 2'd2, 1'b0);             // a+1
    chk("R7 busy", burst_busy_o, 1'b1);
    issue(BST, 2'd0, 1'b0);            // a+2
    chk("R7 cut", burst_busy_o, 1'b0);
    chk("R7 cut no err", err_o, 1'b0);
    chk("R7 row open", rw_ok_o[2], 1'b1);
    issue(RD, 2'd2, 1'b1);             // a+3
    issue(BST, 2'd0, 1'b0);            // a+4
    chk("R7 ap read stop err", err_o, 1'b1);
    chk("R7 ap read continues", burst_busy_o, 1'b1);
    step(2);                           // after a+6
    chk("R7 ap close unaffected", ap_start_o, 4'b0100);
  endtask

  task automatic t_conc();
    do_reset();
    issue(ACT, 2'd0, 1'b0);            // a
    issue(ACT, 2'd1, 1'b0);            // a+1
    issue(RD, 2'd0, 1'b1);             // r = a+2
    chk("R8 lock visible", rw_ok_o[1], 1'b0);
    issue(RD, 2'd1, 1'b0);             // r+1
    chk("R8 interrupt err", err_o, 1'b1);
    step(1);
    issue(RD, 2'd1, 1'b0);             // r+3
    chk("R8 one beat early err", err_o, 1'b1);
    chk("R5 concurrent start", ap_start_o, 4'b0001);
    issue(RD, 2'd1, 1'b0);             // r+4
    chk("R8 last beat ok", err_o, 1'b0);
    chk("R8 other bank busy", burst_busy_o, 1'b1);
    chk("R8 ap bank closed", rw_ok_o, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_illegal();
    t_timing();
    t_allbank();
    t_auto();
    t_bst();
    t_conc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4ns);
    bad++;
    total++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule